// File: doc/BRIEF.md
# Vector Uniform Word Loader

This block turns a stream of 32-bit register writes into four-component vectors of 24-bit floats and stores them in a register file of uniform vectors. A setup write chooses the first vector slot and one of two packings. Data writes are held in a small buffer until one vector is complete. The vector is then unpacked and written in the same clock edge as its last word, and the slot pointer moves to the next entry. This lets software stream a run of vectors after a single setup write.

There are two packings. In the raw packing, three words carry four 24-bit floats laid end to end. In the wide packing, four IEEE single-precision words each become one 24-bit float, and the vector is filled in reverse arrival order. A combinational read port shows any stored vector. A data write aimed at a slot beyond the end of the file is discarded and flagged.

Top module: `vec_uniform_loader`

## Requirements
- R1: After reset every stored vector reads as zero, `err_o` is low, the slot pointer is 0, the packing is raw, and no words are buffered.
- R2: A setup write (`cfg_we`) loads the slot pointer from `cfg_data[7:0]` and the packing from `cfg_data[31]` (1 = wide, 0 = raw), and it empties the word buffer. A data write in the same cycle as a setup write is dropped.
- R3: In raw packing a vector is stored on its third data write. The first two words of a vector change no stored entry.
- R4: With raw words A, B, C taken in arrival order, the vector is x = C[23:0], y = {B[15:0], C[31:24]}, z = {A[7:0], B[31:16]}, w = A[31:8]. `rd_vec` holds x at [23:0], y at [47:24], z at [71:48] and w at [95:72].
- R5: In wide packing a vector is stored on its fourth data write. x comes from the fourth word, y from the third, z from the second and w from the first.
- R6: The single-to-24-bit conversion keeps the sign and takes the exponent minus 64 as a 7-bit field (bias 63). It keeps mantissa bits [22:7] and truncates the rest.
- R7: A single-precision exponent field of 64 or below gives a signed zero. A field of 191 or above, including 255, gives a signed infinity (exponent 0x7F, mantissa 0).
- R8: After each stored vector the slot pointer increments and the buffer empties, so back-to-back vectors fill consecutive entries.
- R9: A data write while the slot pointer is 96 or more leaves every stored entry unchanged and is not buffered. `err_o` is high in the cycle after that write, and low after any in-range write.
- R10: The read port returns the entry at `rd_idx` with no clock delay. An `rd_idx` of 96 or more returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_data | input | 32 | Setup word: slot in [7:0], packing in [31] |
| dat_we | input | 1 | Data write strobe |
| dat_data | input | 32 | Data word |
| rd_idx | input | 7 | Read slot |
| rd_vec | output | 96 | Vector at the read slot, {w,z,y,x} |
| err_o | output | 1 | Out-of-range data write flag, one cycle after the write |

## Verification
A setup write and a data write can land in the same cycle, and a setup write can also land in the middle of a vector. The bench drives both strobes together and then sends a clean three-word vector. It passes only if the target slot holds the value built from those three words alone, which shows the colliding word was dropped and the buffer was emptied. A second collision case sends one stray word, then a setup write, then a full vector, and checks the stored result the same way.

// File: rtl/uni_pkg.sv
package uni_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned F24_W   = 24;
  localparam int unsigned COMP_N  = 4;
  localparam int unsigned VEC_W   = F24_W * COMP_N;
  localparam logic [7:0]  EXP_LOW = 8'd64;   // at or below: flush
  localparam logic [7:0]  EXP_TOP = 8'd191;  // at or above: saturate

  typedef enum logic {FMT_RAW24 = 1'b0, FMT_WIDE32 = 1'b1} fmt_e;

  // single-precision to 1/7/16 float, bias 63, truncating
  function automatic logic [F24_W-1:0] f32_to_f24(input logic [WORD_W-1:0] v);
    logic       s;
    logic [7:0] e;
    logic [7:0] rebased;
    logic       unused_lsb;
    s = v[31];
    e = v[30:23];
    rebased = e - EXP_LOW;
    unused_lsb = ^v[6:0];
    if (e <= EXP_LOW)      return {s, 23'd0};
    else if (e >= EXP_TOP) return {s, 7'h7f, 16'd0};
    else                   return {s, rebased[6:0], v[22:7]};
  endfunction

  // three raw words (arrival order a,b,c) to {w,z,y,x}
  function automatic logic [VEC_W-1:0] unpack_raw(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b,
                                                  input logic [WORD_W-1:0] c);
    logic [F24_W-1:0] x, y, z, w;
    x = c[23:0];
    y = {b[15:0], c[31:24]};
    z = {a[7:0], b[31:16]};
    w = a[31:8];
    return {w, z, y, x};
  endfunction
endpackage

// File: rtl/uni_collector.sv
module uni_collector
  import uni_pkg::*;
#(
  parameter int unsigned NUM_VEC = 96,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned BUF_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_fmt,
  input  logic              dat_we,
  input  logic [WORD_W-1:0] dat_data,
  output logic              store_fire,
  output logic              oor_write,
  output logic [IDX_W-1:0]  cur_idx,
  output fmt_e              cur_fmt,
  output logic [WORD_W-1:0] held [BUF_N]
);
  localparam int unsigned CNT_W = 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             accept;
  logic             in_range;
  logic             last_word;

  assign last_cnt   = (cur_fmt == FMT_WIDE32) ? CNT_W'(3) : CNT_W'(2);
  assign accept     = dat_we && !cfg_we;
  assign in_range   = cur_idx < IDX_W'(NUM_VEC);
  assign last_word  = cnt == last_cnt;
  assign store_fire = accept && in_range && last_word;
  assign oor_write  = accept && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      cur_idx <= '0;
      cur_fmt <= FMT_RAW24;
      for (int k = 0; k < int'(BUF_N); k++) held[k] <= '0;
    end else if (cfg_we) begin
      cnt     <= '0;
      cur_idx <= cfg_idx;
      cur_fmt <= fmt_e'(cfg_fmt);
    end else if (accept && in_range) begin
      if (last_word) begin
        cnt     <= '0;
        cur_idx <= cur_idx + IDX_W'(1);
      end else begin
        for (int k = 0; k < int'(BUF_N); k++)
          if (cnt == CNT_W'(k)) held[k] <= dat_data;
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_SETUP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cnt == '0)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt); // R3
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> (cur_idx == $past(cur_idx) + IDX_W'(1)) && (cnt == '0)); // R8
  AST_NO_OOR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |-> (cur_idx < IDX_W'(NUM_VEC))); // R9
  AST_OOR_HOLDS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    oor_write |=> $stable(cnt)); // R9
endmodule

// File: rtl/uni_convert.sv
module uni_convert
  import uni_pkg::*;
(
  input  fmt_e              fmt,
  input  logic [WORD_W-1:0] held [3],
  input  logic [WORD_W-1:0] incoming,
  output logic [VEC_W-1:0]  vec
);
  logic [WORD_W-1:0] arrived [COMP_N];
  logic [VEC_W-1:0]  wide_vec;
  logic [VEC_W-1:0]  raw_vec;

  assign arrived[0] = held[0];
  assign arrived[1] = held[1];
  assign arrived[2] = held[2];
  assign arrived[3] = incoming;

  // component c (0=x) takes arrival slot COMP_N-1-c
  for (genvar c = 0; c < COMP_N; c++) begin : g_wide
    assign wide_vec[c*F24_W +: F24_W] = f32_to_f24(arrived[COMP_N-1-c]);
  end

  assign raw_vec = unpack_raw(held[0], held[1], incoming);
  assign vec     = (fmt == FMT_WIDE32) ? wide_vec : raw_vec;
endmodule

// File: rtl/uni_regfile.sv
module uni_regfile #(
  parameter int unsigned DEPTH  = 96,
  parameter int unsigned DATA_W = 96,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = (raddr < ADDR_W'(DEPTH)) ? mem[raddr] : '0;

  AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < ADDR_W'(DEPTH))); // R9
  AST_READ_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raddr >= ADDR_W'(DEPTH)) |-> (rdata == '0)); // R10
endmodule

// File: rtl/vec_uniform_loader.sv
module vec_uniform_loader
  import uni_pkg::*;
#(
  parameter int unsigned NUM_VEC = 96,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned RD_W    = $clog2(NUM_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_data,
  input  logic              dat_we,
  input  logic [31:0]       dat_data,
  input  logic [RD_W-1:0]   rd_idx,
  output logic [95:0]       rd_vec,
  output logic              err_o
);
  logic              store_fire;
  logic              oor_write;
  logic [IDX_W-1:0]  cur_idx;
  fmt_e              cur_fmt;
  logic [WORD_W-1:0] held [3];
  logic [VEC_W-1:0]  new_vec;
  logic              err_q;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^cfg_data[30:IDX_W];

  uni_collector #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .BUF_N(3)) u_coll (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_data[IDX_W-1:0]), .cfg_fmt(cfg_data[31]),
    .dat_we(dat_we), .dat_data(dat_data),
    .store_fire(store_fire), .oor_write(oor_write),
    .cur_idx(cur_idx), .cur_fmt(cur_fmt), .held(held)
  );

  uni_convert u_conv (
    .fmt(cur_fmt), .held(held), .incoming(dat_data), .vec(new_vec)
  );

  uni_regfile #(.DEPTH(NUM_VEC), .DATA_W(VEC_W), .ADDR_W(RD_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(store_fire), .waddr(cur_idx[RD_W-1:0]), .wdata(new_vec),
    .raddr(rd_idx), .rdata(rd_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= oor_write;
  end
  assign err_o = err_q;

  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    oor_write |=> err_o); // R9
  AST_ERR_ONLY_OOR: assert property (@(posedge clk) disable iff (!rst_n)
    store_fire |=> !err_o); // R9
  AST_OOR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(oor_write && store_fire)); // R9
endmodule

// File: tb/sim_vec_uniform_loader.sv
`timescale 1ns/1ps
module sim_vec_uniform_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        dat_we = 1'b0;
  logic [31:0] dat_data = '0;
  logic [6:0]  rd_idx = '0;
  logic [95:0] rd_vec;
  logic        err_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vec_uniform_loader u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .dat_we(dat_we), .dat_data(dat_data), .rd_idx(rd_idx),
    .rd_vec(rd_vec), .err_o(err_o)
  );

  // {single-precision input, expected 24-bit float}
  localparam logic [55:0] TBL [12] = '{
    {32'h3F800000, 24'h3F0000}, {32'h40000000, 24'h400000},
    {32'hBFC00000, 24'hBF8000}, {32'h40490FDB, 24'h40921F},
    {32'h00000000, 24'h000000}, {32'h80000000, 24'h800000},
    {32'h20000000, 24'h000000}, {32'h20800000, 24'h010000},
    {32'h5F800000, 24'h7F0000}, {32'h5F7FFFFF, 24'h7EFFFF},
    {32'hFF800000, 24'hFF0000}, {32'h3F000000, 24'h3E0000}
  };

  function automatic logic [95:0] raw_expect(input logic [31:0] a, b, c);
    logic [95:0] all;
    all = {a, b, c};              // a occupies the top word
    return {all[95:72], all[71:48], all[47:24], all[23:0]};
  endfunction

  task automatic chk(input logic [95:0] act, input logic [95:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); dat_we = 1'b1; dat_data = d;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [95:0] v);
    rd_idx = 7'(idx); #0.5; v = rd_vec;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [95:0] v, keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    rd(0, v);  chk(v, '0, "R1 entry0");
    rd(95, v); chk(v, '0, "R1 entry95");
    chk({95'd0, err_o}, '0, "R1 err");

    // R5 R6 R7: table walk, three wide vectors into slots 20..22
    setup(32'h8000_0014);
    for (int g = 0; g < 3; g++)
      for (int j = 0; j < 4; j++) wr(TBL[g*4+j][55:24]);
    for (int g = 0; g < 3; g++) begin
      rd(20 + g, v);
      for (int c = 0; c < 4; c++)
        chk({72'd0, v[c*24 +: 24]}, {72'd0, TBL[g*4 + 3 - c][23:0]},
            $sformatf("R5 R6 R7 vec%0d comp%0d", g, c));
    end

    // R3 R4: raw vector in slot 5, partial words leave it untouched
    setup(32'h0000_0005);
    wr(32'h11223344); wr(32'h55667788);
    rd(5, v); chk(v, '0, "R3 partial");
    wr(32'h99AABBCC);
    rd(5, v); chk(v, raw_expect(32'h11223344, 32'h55667788, 32'h99AABBCC), "R4 raw unpack");
    chk({95'd0, err_o}, '0, "R9 err low after good write");
    // R8: next vector lands in slot 6
    wr(32'hDEADBEEF); wr(32'h01234567); wr(32'h89ABCDEF);
    rd(6, v); chk(v, raw_expect(32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF), "R8 next slot");

    // R2: setup and data in the same cycle, word dropped
    @(negedge clk); cfg_we = 1'b1; cfg_data = 32'h0000_000A; dat_we = 1'b1; dat_data = 32'hFFFFFFFF;
    @(negedge clk); cfg_we = 1'b0; dat_we = 1'b0;
    wr(32'hA0A1A2A3); wr(32'hB0B1B2B3); wr(32'hC0C1C2C3);
    rd(10, v); chk(v, raw_expect(32'hA0A1A2A3, 32'hB0B1B2B3, 32'hC0C1C2C3), "R2 collision");
    // R2: setup mid-vector empties buffer
    wr(32'h77777777);
    setup(32'h0000_000B);
    wr(32'h10203040); wr(32'h50607080); wr(32'h90A0B0C0);
    rd(11, v); chk(v, raw_expect(32'h10203040, 32'h50607080, 32'h90A0B0C0), "R2 mid-vector setup");
    rd(12, v); chk(v, '0, "R2 no stray store");

    // R9: fill last slot then overrun
    setup(32'h0000_005F);
    wr(32'h12345678); wr(32'h9ABCDEF0); wr(32'h0F1E2D3C);
    rd(95, keep);
    chk(keep, raw_expect(32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C), "R9 last slot");
    wr(32'h55555555);
    chk({95'd0, err_o}, 96'd1, "R9 err after overrun");
    wr(32'h66666666); wr(32'h77777777);
    rd(95, v); chk(v, keep, "R9 slot95 unchanged");
    rd(0, v);  chk(v, '0, "R9 slot0 unchanged");
    setup(32'h0000_00C8);
    wr(32'h13579BDF);
    chk({95'd0, err_o}, 96'd1, "R9 err high index");
    @(negedge clk);
    chk({95'd0, err_o}, '0, "R9 err one cycle");

    // R10: out-of-range read
    rd(100, v); chk(v, '0, "R10 oor read");
    rd(127, v); chk(v, '0, "R10 top read");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule